// File: doc/BRIEF.md
# Tower-Field AES Byte Substitution Unit

This block performs the AES forward byte substitution on a single byte with no clock and no storage. It does not look the result up in a 256-entry table. It computes the result arithmetically. A fixed linear map first carries the input byte from the AES field GF(2^8) into a three-level tower field GF(((2^2)^2)^2). The multiplicative inverse is then found there. The inversion splits the byte into two 4-bit halves and needs only one 4-bit inversion. That 4-bit inversion splits again into 2-bit operations. A second fixed linear map does two jobs in one stage: it converts back to the AES field and applies the AES affine transform. The constant 0x63 is added last.

The block is meant to sit in a byte-serial encryption datapath, where it is the largest and most active piece of logic. Keeping it shallow and free of tables keeps both area and switching low.

The tower polynomials and both 8x8 bit matrices are derived when the design is elaborated, not written out by hand. The parameter `ROOT_SEL` picks which of the eight conjugate roots of the AES polynomial defines the isomorphism. Every choice gives the same function at the ports but a different XOR network.

Top module: `tower_sbox`

## Requirements
- R1: For every input byte, `sub_out` equals the standard AES forward substitution of `sub_in`. That is the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the affine transform b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63.
- R2: The corner inputs map as follows: 0x00 gives 0x63, because the inverse of zero is taken as zero; 0x01 gives 0x7C; 0xFF gives 0x16.
- R3: No input maps to itself, and no input maps to its bitwise complement.
- R4: At the output of the tower-field inversion stage, the tower-field product of that stage's input and output is 1 for every nonzero input, and zero maps to zero.
- R5: The input isomorphism maps 0x00 to tower zero and 0x01 to tower one (encoding 0x01). It maps no other byte to zero.
- R6: The result at the ports does not depend on `ROOT_SEL`. Any of the eight conjugate roots gives identical outputs.
- R7: The unit is purely combinational. `sub_out` follows a change of `sub_in` within the same clock period, with no clock edge in between.
- R8: Over all 256 inputs the outputs form a permutation: every byte value appears exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sub_in | input | 8 | Byte to substitute |
| sub_out | output | 8 | Substituted byte |

## Verification
The bench builds two copies of the block side by side. One uses `ROOT_SEL` = 0 and the other uses `ROOT_SEL` = 5, so the two copies differ in both isomorphism matrices and in the merged output matrix. Comparing them cycle by cycle shows that the basis choice is invisible at the ports. The same run drives a full ascending sweep, walking-one and walking-zero bytes, and a pseudo-random sequence. Every result is checked against a table the bench derives from plain polynomial arithmetic in GF(2^8), which reaches the zero corner and the permutation property.

// File: rtl/tower_sbox_pkg.sv
package tower_sbox_pkg;

    typedef logic [1:0]      gf4_t;
    typedef logic [3:0]      gf16_t;
    typedef logic [7:0]      gf256_t;
    typedef logic [7:0][7:0] mat8_t;   // mat[j] is column j (image of bit j)

    // GF(2^2): polynomial basis, w^2 = w + 1
    localparam gf4_t NU = 2'b10;       // w, makes y^2 + y + NU irreducible

    function automatic gf4_t gf4_mul(input gf4_t a, input gf4_t b);
        gf4_t r;
        r[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
        r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
        return r;
    endfunction

    // squaring equals inversion in GF(4)
    function automatic gf4_t gf4_sq(input gf4_t a);
        return {a[1], a[1] ^ a[0]};
    endfunction

    // GF(2^4) = GF(4)[y] / (y^2 + y + NU)
    function automatic gf16_t gf16_mul(input gf16_t a, input gf16_t b);
        gf4_t lo_p;
        lo_p = gf4_mul(a[1:0], b[1:0]);
        return {gf4_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]) ^ lo_p,
                gf4_mul(NU, gf4_mul(a[3:2], b[3:2])) ^ lo_p};
    endfunction

    function automatic gf16_t gf16_inv(input gf16_t a);
        gf4_t nrm, ninv;
        nrm  = gf4_mul(NU, gf4_sq(a[3:2])) ^ gf4_mul(a[3:2], a[1:0]) ^ gf4_sq(a[1:0]);
        ninv = gf4_sq(nrm);
        return {gf4_mul(a[3:2], ninv), gf4_mul(a[3:2] ^ a[1:0], ninv)};
    endfunction

    // smallest constant making z^2 + z + c irreducible over GF(16)
    function automatic gf16_t pick_lambda();
        gf16_t sel;
        bit    ok;
        sel = 4'h0;
        for (int l = 15; l >= 1; l--) begin
            ok = 1'b1;
            for (int r = 0; r < 16; r++)
                if ((gf16_mul(4'(r), 4'(r)) ^ 4'(r) ^ 4'(l)) == 4'h0) ok = 1'b0;
            if (ok) sel = 4'(l);
        end
        return sel;
    endfunction

    localparam gf16_t LAMBDA = pick_lambda();

    // GF(2^8) tower = GF(16)[z] / (z^2 + z + LAMBDA)
    function automatic gf256_t gf256_mul(input gf256_t a, input gf256_t b);
        gf16_t lo_p;
        lo_p = gf16_mul(a[3:0], b[3:0]);
        return {gf16_mul(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0]) ^ lo_p,
                gf16_mul(LAMBDA, gf16_mul(a[7:4], b[7:4])) ^ lo_p};
    endfunction

    // AES polynomial evaluated at a tower element
    function automatic gf256_t aes_poly_at(input gf256_t t);
        gf256_t t2, t3, t4, t8;
        t2 = gf256_mul(t, t);
        t3 = gf256_mul(t2, t);
        t4 = gf256_mul(t2, t2);
        t8 = gf256_mul(t4, t4);
        return t8 ^ t4 ^ t3 ^ t ^ 8'h01;
    endfunction

    function automatic gf256_t first_root();
        gf256_t r;
        bit     found;
        int     t;
        r = 8'h00;
        found = 1'b0;
        t = 2;
        while (!found && t < 256) begin
            if (aes_poly_at(8'(t)) == 8'h00) begin
                r = 8'(t);
                found = 1'b1;
            end
            t++;
        end
        return r;
    endfunction

    // conjugate roots: repeated squaring, period 8
    function automatic gf256_t root_conj(input int unsigned k);
        gf256_t b;
        b = first_root();
        for (int i = 0; i < int'(k % 8); i++) b = gf256_mul(b, b);
        return b;
    endfunction

    function automatic mat8_t pow_cols(input gf256_t beta);
        mat8_t  c;
        gf256_t p;
        p = 8'h01;
        for (int i = 0; i < 8; i++) begin
            c[i] = p;
            p    = gf256_mul(p, beta);
        end
        return c;
    endfunction

    function automatic mat8_t transpose8(input mat8_t m);
        mat8_t t;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                t[i][j] = m[j][i];
        return t;
    endfunction

    // Gauss-Jordan inverse over GF(2); columns in, columns out
    function automatic mat8_t mat_inv(input mat8_t cols);
        mat8_t  a, g;
        gf256_t tr;
        a = transpose8(cols);
        g = '0;
        for (int i = 0; i < 8; i++) g[i][i] = 1'b1;
        for (int c = 0; c < 8; c++) begin
            for (int p = c + 1; p < 8; p++)
                if (!a[c][c] && a[p][c]) begin
                    tr = a[c]; a[c] = a[p]; a[p] = tr;
                    tr = g[c]; g[c] = g[p]; g[p] = tr;
                end
            for (int r = 0; r < 8; r++)
                if (r != c && a[r][c]) begin
                    a[r] = a[r] ^ a[c];
                    g[r] = g[r] ^ g[c];
                end
        end
        return transpose8(g);
    endfunction

    function automatic gf256_t aff_lin(input gf256_t b);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]};
    endfunction

    function automatic mat8_t merge_affine(input mat8_t back_cols);
        mat8_t m;
        for (int j = 0; j < 8; j++) m[j] = aff_lin(back_cols[j]);
        return m;
    endfunction

endpackage

// File: rtl/tf_lin_map.sv
module tf_lin_map
    import tower_sbox_pkg::*;
#(
    parameter mat8_t  COLS = '0,
    parameter gf256_t KADD = '0
) (
    input  gf256_t vin,
    output gf256_t vout
);
    localparam mat8_t ROWS = transpose8(COLS);

    // one XOR tree per output bit
    for (genvar i = 0; i < 8; i++) begin : g_row
        assign vout[i] = (^(vin & ROWS[i])) ^ KADD[i];
    end
endmodule

// File: rtl/tf_nib_inv.sv
module tf_nib_inv
    import tower_sbox_pkg::*;
(
    input  gf16_t nib_in,
    output gf16_t nib_out
);
    typedef struct packed {
        gf4_t hi;
        gf4_t lo;
        gf4_t nrm;
        gf4_t ninv;
    } nib_stage_t;

    nib_stage_t st_d;

    always_comb begin
        st_d.hi   = nib_in[3:2];
        st_d.lo   = nib_in[1:0];
        st_d.nrm  = gf4_mul(NU, gf4_sq(st_d.hi)) ^ gf4_mul(st_d.hi, st_d.lo) ^ gf4_sq(st_d.lo);
        st_d.ninv = gf4_sq(st_d.nrm);
        nib_out   = {gf4_mul(st_d.hi, st_d.ninv), gf4_mul(st_d.hi ^ st_d.lo, st_d.ninv)};
    end
endmodule

// File: rtl/tf_byte_inv.sv
module tf_byte_inv
    import tower_sbox_pkg::*;
(
    input  gf256_t byte_in,
    output gf256_t byte_out
);
    typedef struct packed {
        gf16_t hi;
        gf16_t sum;
        gf16_t nrm;
    } byte_stage_t;

    byte_stage_t st_d;
    gf16_t       ninv_d;

    always_comb begin
        st_d.hi  = byte_in[7:4];
        st_d.sum = byte_in[7:4] ^ byte_in[3:0];
        st_d.nrm = gf16_mul(LAMBDA, gf16_mul(byte_in[7:4], byte_in[7:4]))
                 ^ gf16_mul(byte_in[7:4], byte_in[3:0])
                 ^ gf16_mul(byte_in[3:0], byte_in[3:0]);
    end

    tf_nib_inv u_nrm_inv (
        .nib_in  (st_d.nrm),
        .nib_out (ninv_d)
    );

    always_comb begin
        byte_out = {gf16_mul(st_d.hi, ninv_d), gf16_mul(st_d.sum, ninv_d)};
    end
endmodule

// File: rtl/tower_sbox.sv
module tower_sbox
    import tower_sbox_pkg::*;
#(
    parameter int unsigned ROOT_SEL = 0
) (
    input  logic [7:0] sub_in,
    output logic [7:0] sub_out
);
    localparam gf256_t BETA     = root_conj(ROOT_SEL);
    localparam mat8_t  FWD_COLS = pow_cols(BETA);
    localparam mat8_t  OUT_COLS = merge_affine(mat_inv(FWD_COLS));

    gf256_t tw_fwd_d;
    gf256_t tw_inv_d;

    tf_lin_map #(.COLS(FWD_COLS), .KADD(8'h00)) u_map_in (
        .vin  (sub_in),
        .vout (tw_fwd_d)
    );

    tf_byte_inv u_inv (
        .byte_in  (tw_fwd_d),
        .byte_out (tw_inv_d)
    );

    tf_lin_map #(.COLS(OUT_COLS), .KADD(8'h63)) u_map_out (
        .vin  (tw_inv_d),
        .vout (sub_out)
    );
endmodule

// File: rtl/tower_sbox_chk.sv
module tower_sbox_chk
    import tower_sbox_pkg::*;
(
    input logic [7:0] sub_in,
    input logic [7:0] sub_out,
    input logic [7:0] tw_fwd,
    input logic [7:0] tw_inv
);
    always_comb begin
        AST_ZERO_MAPS_63: assert (sub_in != 8'h00 || sub_out == 8'h63) else $error("zero corner"); // R2
        AST_NO_FIXED_POINT: assert (sub_out != sub_in) else $error("fixed point"); // R3
        AST_NO_OPPOSITE_POINT: assert (sub_out != ~sub_in) else $error("opposite point"); // R3
        AST_INV_PRODUCT_ONE: assert ((tw_fwd == 8'h00 && tw_inv == 8'h00) || gf256_mul(tw_fwd, tw_inv) == 8'h01) else $error("tower inverse"); // R4
        AST_ISO_KEEPS_ONE: assert (sub_in != 8'h01 || tw_fwd == 8'h01) else $error("iso one"); // R5
        AST_ISO_KEEPS_ZERO: assert ((sub_in == 8'h00) == (tw_fwd == 8'h00)) else $error("iso zero"); // R5
    end
endmodule

bind tower_sbox tower_sbox_chk u_chk (
    .sub_in  (sub_in),
    .sub_out (sub_out),
    .tw_fwd  (tw_fwd_d),
    .tw_inv  (tw_inv_d)
);

// File: tb/tower_sbox_tb.sv
`timescale 1ns/1ps
module tower_sbox_tb;

    logic       clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic [7:0] dalt;

    tower_sbox u_dut (.sub_in(din), .sub_out(dout));
    tower_sbox #(.ROOT_SEL(5)) u_dut_alt (.sub_in(din), .sub_out(dalt));

    logic [7:0] ref_tab [256];
    logic [7:0] exp_q [$];
    logic [7:0] in_q  [$];
    bit         seen  [256];
    bit         track = 1'b0;
    bit         done  = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        logic [7:0] y = b;
        for (int i = 0; i < 8; i++) begin
            if (y[0]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] ref_sub(input logic [7:0] v);
        logic [7:0] inv = 8'h00;
        for (int c = 1; c < 256; c++)
            if (ref_mul(v, 8'(c)) == 8'h01) inv = 8'(c);
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // reference queue compared on every falling edge
    always @(negedge clk) begin
        logic [7:0] e;
        logic [7:0] i;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            i = in_q.pop_front();
            chk(dout == e, "R1 substitution", dout, e);
            chk(dalt == dout, "R6 root choice", dalt, dout);
            chk(dout != i && dout != ~i, "R3 fixed/opposite point", dout, i);
            if (track) seen[dout] = 1'b1;
        end
    end

    task automatic drive(input logic [7:0] v);
        @(posedge clk);
        #1;
        din = v;
        exp_q.push_back(ref_tab[v]);
        in_q.push_back(v);
    endtask

    task automatic drain();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
        finish_run();
    end

    initial begin
        logic [7:0] lfsr;
        int         distinct;
        for (int v = 0; v < 256; v++) ref_tab[v] = ref_sub(8'(v));

        // quiet start with zero held on the input
        din = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dout == 8'h63, "R2 zero at start", dout, 8'h63);

        // full ascending sweep, permutation tracking
        track = 1'b1;
        for (int v = 0; v < 256; v++) drive(8'(v));
        drain();
        track = 1'b0;
        distinct = 0;
        for (int v = 0; v < 256; v++) if (seen[v]) distinct++;
        chk(distinct == 256, "R8 permutation", 8'(distinct), 8'h00);

        // walking one and walking zero
        for (int b = 0; b < 8; b++) begin
            drive(8'(1 << b));
            drive(~8'(1 << b));
        end
        drain();

        // corner values
        @(posedge clk); #1 din = 8'h00;
        @(negedge clk); chk(dout == 8'h63, "R2 zero", dout, 8'h63);
        @(posedge clk); #1 din = 8'h01;
        @(negedge clk); chk(dout == 8'h7C, "R2 one", dout, 8'h7C);
        @(posedge clk); #1 din = 8'hFF;
        @(negedge clk); chk(dout == 8'h16, "R2 all ones", dout, 8'h16);

        // R7: changes within one period, no edge between
        @(posedge clk); #0.2;
        din = 8'h53;
        #0.5 chk(dout == ref_tab[8'h53], "R7 combinational", dout, ref_tab[8'h53]);
        din = 8'hC9;
        #0.5 chk(dout == ref_tab[8'hC9], "R7 combinational", dout, ref_tab[8'hC9]);
        din = 8'h00;
        #0.5 chk(dout == 8'h63, "R7 combinational", dout, 8'h63);

        // pseudo-random pattern
        lfsr = 8'h5A;
        for (int n = 0; n < 64; n++) begin
            drive(lfsr);
            lfsr = lfsr[0] ? ((lfsr >> 1) ^ 8'hB8) : (lfsr >> 1);
        end
        drain();

        finish_run();
    end

endmodule